// File: doc/BRIEF.md
# TDM Multichannel Serial Transmitter

This block sends CPU-supplied words over a single serial data pin in a repeating time-division frame. Each frame holds a fixed number of channel slots, and each slot is one word long. A bit timer divides the system clock into bit periods. It emits a one-bit frame pulse and keeps track of the current slot and bit.

Software writes each word into a holding register. The block copies it into a shift register at the start of every slot that takes a word. The word then leaves the pin most-significant bit first. A ready output tells software when the holding register is free again. If a copy falls due before a new word has arrived, the old word is sent a second time and a sticky underflow flag is raised.

A two-bit mode field sets how the per-channel enable bits act. A block-select field picks the group of channels that those bits cover. A disabled channel can skip its slot entirely, so it takes no word. It can instead be masked, so it takes a word but the pin is released for that slot. The configuration is captured at each frame start, which means a change only affects the next whole frame.

Top module: `tdm_tx`

## Requirements
- R1: A frame is NUM_CH slots of WORD_W bits with no gaps, and each bit lasts DIV clock cycles. The first frame begins with the first bit period after reset is released.
- R2: `fsync` is high for exactly the first bit period of slot 0 in every frame and low at all other times.
- R3: With mode 2'b00, and also with 2'b11, every slot takes one word and drives it (`tx_oe` high) whatever the enable bits say.
- R4: With mode 2'b01, a slot whose channel is selected takes a word and drives it. Any other slot takes no word, and `tx_oe` is low for its whole width.
- R5: With mode 2'b10, every slot takes a word. Only selected channels drive the pin; masked slots keep `tx_oe` low for the whole slot.
- R6: Slot n is selected when n / BLK_W equals `cfg_blk` and bit (n mod BLK_W) of `cfg_chan_en` is 1. Slots in any other block are never selected.
- R7: Data goes out MSB first. Bit j of a slot (j = 0 first) carries word bit WORD_W-1-j. `tx_data` is 0 whenever `tx_oe` is low.
- R8: `tx_ready` is 1 after reset. It is 0 from the cycle after a write. It is 1 again from the cycle after a slot start that takes a word, unless a write happens in that same cycle.
- R9: If a slot takes a word while no new word has been written since the previous copy, it sends the previous word again. `underflow` then rises at that slot start and stays high until reset.
- R10: The mode, block and enable inputs are sampled at each frame start. Changes made during a frame take effect from the next frame.
- R11: During reset, `tx_oe`, `tx_data`, `fsync` and `underflow` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Slot mode (00/11 all, 01 skip disabled, 10 mask disabled) |
| cfg_blk | input | SEL_W | Index of the channel block the enable bits cover |
| cfg_chan_en | input | BLK_W | Per-channel enable bits for the selected block |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | WORD_W | Word to transmit |
| tx_ready | output | 1 | Holding register can take a new word |
| underflow | output | 1 | Sticky: a word was sent again for lack of a new one |
| bit_clk | output | 1 | Divided bit clock, high in the second half of each bit |
| fsync | output | 1 | Frame pulse, one bit period wide |
| tx_data | output | 1 | Serial data |
| tx_oe | output | 1 | Output enable for the data pin |

## Verification
Each new bit, together with `fsync`, `tx_oe`, `tx_ready` and `underflow`, appears at the clock edge that ends a bit period. The bench finds the first frame pulse, samples on the falling edge after it, and then steps exactly DIV cycles per bit, so every sample falls in the middle of its bit. `tx_ready` is due one cycle after a write, so the writer process checks it on the next falling edge. A configuration change is due one full frame later, so the bench applies the next configuration during bit 0 of a frame and still expects the old one for the rest of that frame. The sweep covers both reserved-value modes, every enable pattern on both blocks in skip and mask modes, and a final frame in which writes stop.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    typedef enum logic [1:0] {
        MODE_ALL     = 2'b00,
        MODE_SKIP    = 2'b01,
        MODE_MASK    = 2'b10,
        MODE_ALL_ALT = 2'b11
    } tx_mode_e;

    // What a slot does with the holding register and the pin
    typedef struct packed {
        logic consume;
        logic drive;
    } slot_plan_t;

    function automatic slot_plan_t plan_slot(input tx_mode_e mode, input logic picked);
        slot_plan_t p;
        case (mode)
            MODE_SKIP: begin
                p.consume = picked;
                p.drive   = picked;
            end
            MODE_MASK: begin
                p.consume = 1'b1;
                p.drive   = picked;
            end
            default: begin
                p.consume = 1'b1;
                p.drive   = 1'b1;
            end
        endcase
        return p;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer import tdm_tx_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int WORD_W = 8,
    parameter int DIV    = 2,
    localparam int SLOT_W = idx_width(NUM_CH),
    localparam int BIT_W  = idx_width(WORD_W),
    localparam int DIV_W  = idx_width(DIV)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              bit_stb,
    output logic              slot_load,
    output logic              frame_start,
    output logic [SLOT_W-1:0] next_slot,
    output logic              fsync,
    output logic              bit_clk
);

    logic [DIV_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              started;
    logic              last_bit;
    logic              last_slot;

    assign bit_stb     = (div_cnt == DIV_W'(DIV - 1));
    assign bit_clk     = (div_cnt >= DIV_W'(DIV / 2));
    assign last_bit    = (bit_idx == BIT_W'(WORD_W - 1));
    assign last_slot   = (slot_idx == SLOT_W'(NUM_CH - 1));
    assign slot_load   = bit_stb && (!started || last_bit);
    assign next_slot   = (!started || last_slot) ? '0 : slot_idx + SLOT_W'(1);
    assign frame_start = slot_load && (next_slot == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (bit_stb) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started  <= 1'b0;
            bit_idx  <= '0;
            slot_idx <= '0;
            fsync    <= 1'b0;
        end else if (bit_stb) begin
            started <= 1'b1;
            fsync   <= frame_start;
            if (slot_load) begin
                bit_idx  <= '0;
                slot_idx <= next_slot;
            end else begin
                bit_idx <= bit_idx + BIT_W'(1);
            end
        end
    end

    // R1
    stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R2
    fsync_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        fsync && bit_stb |=> !fsync);

endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select import tdm_tx_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int BLK_W  = 4,
    parameter int SEL_W  = 1,
    localparam int SLOT_W = idx_width(NUM_CH)
) (
    input  tx_mode_e          mode,
    input  logic [SEL_W-1:0]  blk_sel,
    input  logic [BLK_W-1:0]  chan_en,
    input  logic [SLOT_W-1:0] slot,
    output slot_plan_t        plan
);

    logic [NUM_CH-1:0] picked_vec;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pick
        localparam int BLK = g / BLK_W;
        localparam int POS = g % BLK_W;
        assign picked_vec[g] = (blk_sel == SEL_W'(BLK)) && chan_en[POS];
    end

    assign plan = plan_slot(mode, picked_vec[slot]);

endmodule

// File: rtl/tdm_tx_buffer.sv
module tdm_tx_buffer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              bit_stb,
    input  logic              load,
    input  logic              consume,
    output logic              tx_ready,
    output logic              underflow,
    output logic              msb
);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shift_q;
    logic              full_q;
    logic              uflow_q;
    logic              take;

    assign take = load && consume;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
            full_q  <= 1'b0;
            uflow_q <= 1'b0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data;
            end
            if (take) begin
                shift_q <= hold_q;
            end else if (bit_stb) begin
                shift_q <= {shift_q[WORD_W-2:0], 1'b0};
            end
            if (wr_en) begin
                full_q <= 1'b1;
            end else if (take) begin
                full_q <= 1'b0;
            end
            if (take && !full_q) begin
                uflow_q <= 1'b1;
            end
        end
    end

    assign tx_ready  = !full_q;
    assign underflow = uflow_q;
    assign msb       = shift_q[WORD_W-1];

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_ready);

    // R8
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        take && !wr_en |=> tx_ready);

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    // R9
    stale_word_kept_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready && !wr_en |=> $stable(hold_q));

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx import tdm_tx_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int BLK_W  = 4,
    parameter int WORD_W = 8,
    parameter int DIV    = 2,
    localparam int NUM_BLK = NUM_CH / BLK_W,
    localparam int SEL_W   = idx_width(NUM_BLK),
    localparam int SLOT_W  = idx_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [SEL_W-1:0]  cfg_blk,
    input  logic [BLK_W-1:0]  cfg_chan_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_ready,
    output logic              underflow,
    output logic              bit_clk,
    output logic              fsync,
    output logic              tx_data,
    output logic              tx_oe
);

    logic              bit_stb;
    logic              slot_load;
    logic              frame_start;
    logic [SLOT_W-1:0] next_slot;
    logic              msb;

    tx_mode_e          mode_q;
    logic [SEL_W-1:0]  blk_q;
    logic [BLK_W-1:0]  en_q;
    tx_mode_e          mode_eff;
    logic [SEL_W-1:0]  blk_eff;
    logic [BLK_W-1:0]  en_eff;
    slot_plan_t        plan;
    logic              oe_q;

    tdm_bit_timer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .DIV(DIV)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .slot_load  (slot_load),
        .frame_start(frame_start),
        .next_slot  (next_slot),
        .fsync      (fsync),
        .bit_clk    (bit_clk)
    );

    // Frame-start sampling of the configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ALL;
            blk_q  <= '0;
            en_q   <= '0;
        end else if (frame_start) begin
            mode_q <= tx_mode_e'(cfg_mode);
            blk_q  <= cfg_blk;
            en_q   <= cfg_chan_en;
        end
    end

    assign mode_eff = frame_start ? tx_mode_e'(cfg_mode) : mode_q;
    assign blk_eff  = frame_start ? cfg_blk : blk_q;
    assign en_eff   = frame_start ? cfg_chan_en : en_q;

    tdm_slot_select #(.NUM_CH(NUM_CH), .BLK_W(BLK_W), .SEL_W(SEL_W)) i_select (
        .mode   (mode_eff),
        .blk_sel(blk_eff),
        .chan_en(en_eff),
        .slot   (next_slot),
        .plan   (plan)
    );

    tdm_tx_buffer #(.WORD_W(WORD_W)) i_buffer (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bit_stb  (bit_stb),
        .load     (slot_load),
        .consume  (plan.consume),
        .tx_ready (tx_ready),
        .underflow(underflow),
        .msb      (msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else if (slot_load) begin
            oe_q <= plan.drive;
        end
    end

    assign tx_oe   = oe_q;
    assign tx_data = oe_q & msb;

    // R5
    hidden_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        slot_load && !plan.drive |=> !tx_oe);

    // R4
    driven_slot_has_word_chk: assert property (@(posedge clk) disable iff (rst)
        slot_load && plan.drive |-> plan.consume);

    // R7
    quiet_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_data);

endmodule

// File: tb/test_tdm_tx.sv
module test_tdm_tx;

    localparam int NUM_CH = 8;
    localparam int BLK_W  = 4;
    localparam int WORD_W = 8;
    localparam int DIV    = 2;
    localparam int LAST_CFG = 66;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       cfg_mode;
    logic             cfg_blk;
    logic [BLK_W-1:0] cfg_chan_en;
    logic             wr_en;
    logic [WORD_W-1:0] wr_data;
    logic tx_ready, underflow, bit_clk, fsync, tx_data, tx_oe;

    int  checks = 0;
    int  errors = 0;
    int  wcount = 0;
    int  m_used = 0;
    bit  feeding = 1'b0;
    bit  exp_uf = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    tdm_tx #(.NUM_CH(NUM_CH), .BLK_W(BLK_W), .WORD_W(WORD_W), .DIV(DIV)) i_tdm_tx (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_blk(cfg_blk),
        .cfg_chan_en(cfg_chan_en), .wr_en(wr_en), .wr_data(wr_data),
        .tx_ready(tx_ready), .underflow(underflow), .bit_clk(bit_clk),
        .fsync(fsync), .tx_data(tx_data), .tx_oe(tx_oe)
    );

    function automatic logic [WORD_W-1:0] wseq(input int k);
        return WORD_W'(k * 37 + 11);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic cfg_of(input int i, output logic [1:0] md, output logic bk, output logic [3:0] en);
        md = 2'b00; bk = 1'b0; en = 4'b0000;
        if (i == 1) begin
            md = 2'b11; en = 4'b0101;
        end else if (i >= 2 && i < 34) begin
            md = 2'b01; bk = 1'((i - 2) / 16); en = 4'((i - 2) % 16);
        end else if (i >= 34 && i < 66) begin
            md = 2'b10; bk = 1'((i - 34) / 16); en = 4'((i - 34) % 16);
        end
    endtask

    // Writer: plays software, refilling whenever ready
    initial begin
        wr_en = 1'b0;
        wr_data = '0;
        wait (feeding);
        forever begin
            if (feeding && tx_ready) begin
                wr_en = 1'b1;
                wr_data = wseq(wcount);
                wcount++;
                @(negedge clk);
                wr_en = 1'b0;
                // R8: ready drops the cycle after a write
                chk("R8", "ready after write", int'(tx_ready), 0);
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic check_frame(input int i, input logic [1:0] md, input logic bk, input logic [3:0] en);
        bit cons = 1'b0;
        bit drv = 1'b0;
        logic [WORD_W-1:0] word = '0;
        string otag;
        otag = (md == 2'b01) ? "R4 R6 R10" : (md == 2'b10) ? "R5 R6 R10" : "R3";
        for (int b = 0; b < NUM_CH * WORD_W; b++) begin
            int s = b / WORD_W;
            int j = b % WORD_W;
            if (j == 0) begin
                bit pk = ((s / BLK_W) == int'(bk)) && en[s % BLK_W];
                cons = (md == 2'b01) ? pk : 1'b1;
                drv  = (md == 2'b01 || md == 2'b10) ? pk : 1'b1;
                if (cons) begin
                    if (m_used < wcount) begin
                        word = wseq(m_used);
                    end else begin
                        word = wseq(wcount - 1);
                        exp_uf = 1'b1;
                    end
                    m_used++;
                end
                chk("R8", "ready at slot start", int'(tx_ready), int'(cons));
                chk("R9", "underflow flag", int'(underflow), int'(exp_uf));
            end
            if (j == 1 && cons && i < LAST_CFG) begin
                chk("R8", "ready refilled", int'(tx_ready), 0);
            end
            chk("R1 R2", "fsync", int'(fsync), int'(b == 0));
            chk(otag, "tx_oe", int'(tx_oe), int'(drv));
            chk("R7", "tx_data", int'(tx_data), drv ? int'(word[WORD_W-1-j]) : 0);
            if (i == LAST_CFG && b == 2) begin
                feeding = 1'b0;
            end
            repeat (DIV) @(negedge clk);
        end
    endtask

    initial begin
        logic [1:0] md;
        logic bk;
        logic [3:0] en;
        rst = 1'b1;
        cfg_of(0, md, bk, en);
        cfg_mode = md; cfg_blk = bk; cfg_chan_en = en;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11", "ready", int'(tx_ready), 1);
        chk("R11", "tx_oe", int'(tx_oe), 0);
        chk("R11", "tx_data", int'(tx_data), 0);
        chk("R11", "fsync", int'(fsync), 0);
        chk("R11", "underflow", int'(underflow), 0);
        rst = 1'b0;
        feeding = 1'b1;
        while (fsync !== 1'b1) @(negedge clk);
        for (int i = 0; i <= LAST_CFG; i++) begin
            logic [1:0] nmd;
            logic nbk;
            logic [3:0] nen;
            cfg_of(i, md, bk, en);
            if (i < LAST_CFG) begin
                // R10: next frame's settings applied during this frame
                cfg_of(i + 1, nmd, nbk, nen);
                cfg_mode = nmd; cfg_blk = nbk; cfg_chan_en = nen;
            end
            check_frame(i, md, bk, en);
        end
        chk("R9", "underflow seen in starved frame", int'(underflow), 1);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule